// File: doc/BRIEF.md
# Masked Torus Mesh Routing Network

This block is the data-routing fabric of a lock-step processing array. Each of the N = SIDE×SIDE processing elements owns one routing register. On a routing step, every element sends its register to one neighbour, and a single function code picks that neighbour for the whole array: the next element, the previous element, the element one row ahead or the element one row back, all wrapping modulo N so that the array forms a torus. To reach an element that is not a neighbour, the controller issues a sequence of steps.

A per-element status flag decides which elements may transmit. An element whose flag is clear sends nothing, so the element that would have received its value keeps what it holds. A disabled element can still take in a value from an enabled source. The flags can be reloaded from a mask input. A reload issued in the same cycle as a step governs that step. The routing registers can also be loaded in parallel from outside, and a done pulse follows every step that is taken.

Top module: `mesh_route_top`

## Requirements
- R1: After reset, every routing register is zero, every status flag is set (all elements enabled) and done is low.
- R2: When regLoad is high at a clock edge, every routing register takes its slice of regIn (element j at bits [j*WIDTH +: WIDTH]). regLoad has priority over stepStrobe: a step issued in the same cycle is dropped and produces no done pulse.
- R3: A step with funcSel = 2'b00 copies the register of element i into element (i+1) mod N.
- R4: A step with funcSel = 2'b01 copies the register of element i into element (i−1) mod N.
- R5: A step with funcSel = 2'b10 copies the register of element i into element (i+SIDE) mod N.
- R6: A step with funcSel = 2'b11 copies the register of element i into element (i−SIDE) mod N.
- R7: An element whose status flag is 0 sends nothing, and its destination keeps its previous value. An element whose flag is 0 still receives the value from an enabled source.
- R8: When maskLoad is high at a clock edge, the status flags take maskIn (bit i = 1 enables element i). A step in the same cycle already uses the new mask, and the flags keep their value until the next load.
- R9: For a step sampled at clock edge E, the registers change at E and done is high for exactly the one cycle between edges E+1 and E+2.
- R10: With neither regLoad nor stepStrobe high, all routing registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regLoad | input | 1 | Parallel load of all routing registers from regIn |
| regIn | input | N*WIDTH | Load values, element j at [j*WIDTH +: WIDTH] |
| maskLoad | input | 1 | Load the status flags from maskIn |
| maskIn | input | N | Mask, bit i = 1 enables element i |
| stepStrobe | input | 1 | Perform one routing step |
| funcSel | input | 2 | Routing function: 00 +1, 01 −1, 10 +SIDE, 11 −SIDE |
| regOut | output | N*WIDTH | Current routing registers, element j at [j*WIDTH +: WIDTH] |
| done | output | 1 | One-cycle pulse following each step that is taken |

## Verification
Register loads and routing steps become visible at the same edge that samples the strobe. The bench drives inputs on the falling edge and compares all of regOut with its own torus model at the next falling edge. The done pulse is due one edge later. It is checked low at the first falling edge after the step, high at the second and low again at the third. Priority of a load over a step and the hold of idle cycles are checked at the same first falling edge, and done is confirmed to stay low across the following two.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

  typedef enum logic [1:0] {
    FN_PLUS1  = 2'b00,
    FN_MINUS1 = 2'b01,
    FN_PLUSR  = 2'b10,
    FN_MINUSR = 2'b11
  } routeFn_e;

  typedef struct packed {
    logic     loadRegs;
    logic     doStep;
    logic     loadMask;
    routeFn_e fn;
  } meshCtrl_t;

endpackage

// File: rtl/mesh_route_ctrl.sv
module mesh_route_ctrl
  import mesh_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regLoad,
  input  logic       maskLoad,
  input  logic       stepStrobe,
  input  logic [1:0] funcSel,
  output meshCtrl_t  ctrl,
  output logic       done
);

  logic stepPend;

  always_comb begin
    ctrl.loadRegs = regLoad;
    ctrl.doStep   = stepStrobe & ~regLoad;
    ctrl.loadMask = maskLoad;
    ctrl.fn       = routeFn_e'(funcSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPend <= 1'b0;
      done     <= 1'b0;
    end else begin
      stepPend <= ctrl.doStep;
      done     <= stepPend;
    end
  end

endmodule

// File: rtl/mesh_route_datapath.sv
module mesh_route_datapath
  import mesh_route_pkg::*;
#(
  parameter  int SIDE  = 8,
  parameter  int WIDTH = 8,
  localparam int N     = SIDE * SIDE
) (
  input  logic             clk,
  input  logic             rstN,
  input  meshCtrl_t        ctrl,
  input  logic [N*WIDTH-1:0] regIn,
  input  logic [N-1:0]     maskIn,
  output logic [N*WIDTH-1:0] regOut
);

  logic [WIDTH-1:0] routeQ [N];
  logic [N-1:0]     statusQ;
  logic [N-1:0]     maskEff;

  assign maskEff = ctrl.loadMask ? maskIn : statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              statusQ <= '1;
    else if (ctrl.loadMask) statusQ <= maskIn;
  end

  for (genvar j = 0; j < N; j++) begin : gElem
    localparam int SRC_P1 = (j + N - 1) % N;
    localparam int SRC_M1 = (j + 1) % N;
    localparam int SRC_PR = (j + N - SIDE) % N;
    localparam int SRC_MR = (j + SIDE) % N;

    logic [WIDTH-1:0] srcVal;
    logic             srcEn;
    logic [WIDTH-1:0] nextVal;

    always_comb begin
      unique case (ctrl.fn)
        FN_PLUS1:  begin srcVal = routeQ[SRC_P1]; srcEn = maskEff[SRC_P1]; end
        FN_MINUS1: begin srcVal = routeQ[SRC_M1]; srcEn = maskEff[SRC_M1]; end
        FN_PLUSR:  begin srcVal = routeQ[SRC_PR]; srcEn = maskEff[SRC_PR]; end
        default:   begin srcVal = routeQ[SRC_MR]; srcEn = maskEff[SRC_MR]; end
      endcase
      nextVal = srcEn ? srcVal : routeQ[j];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              routeQ[j] <= '0;
      else if (ctrl.loadRegs) routeQ[j] <= regIn[j*WIDTH +: WIDTH];
      else if (ctrl.doStep)   routeQ[j] <= nextVal;
    end

    assign regOut[j*WIDTH +: WIDTH] = routeQ[j];
  end

endmodule

// File: rtl/mesh_route_top.sv
module mesh_route_top
  import mesh_route_pkg::*;
#(
  parameter  int SIDE  = 8,
  parameter  int WIDTH = 8,
  localparam int N     = SIDE * SIDE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regLoad,
  input  logic [N*WIDTH-1:0] regIn,
  input  logic               maskLoad,
  input  logic [N-1:0]       maskIn,
  input  logic               stepStrobe,
  input  logic [1:0]         funcSel,
  output logic [N*WIDTH-1:0] regOut,
  output logic               done
);

  meshCtrl_t ctrl;

  mesh_route_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regLoad    (regLoad),
    .maskLoad   (maskLoad),
    .stepStrobe (stepStrobe),
    .funcSel    (funcSel),
    .ctrl       (ctrl),
    .done       (done)
  );

  mesh_route_datapath #(.SIDE(SIDE), .WIDTH(WIDTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .regIn  (regIn),
    .maskIn (maskIn),
    .regOut (regOut)
  );

endmodule

// File: rtl/mesh_route_chk.sv
module mesh_route_chk #(
  parameter  int SIDE  = 8,
  parameter  int WIDTH = 8,
  localparam int N     = SIDE * SIDE
) (
  input logic               clk,
  input logic               rstN,
  input logic               regLoad,
  input logic [N*WIDTH-1:0] regIn,
  input logic               maskLoad,
  input logic [N-1:0]       maskIn,
  input logic               stepStrobe,
  input logic [1:0]         funcSel,
  input logic [N*WIDTH-1:0] regOut,
  input logic               done
);

  AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    regLoad |=> regOut == $past(regIn)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!regLoad && !stepStrobe) |=> $stable(regOut)); // R10

  AST_PLUS1_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !regLoad && maskLoad && (&maskIn) && funcSel == 2'b00)
    |=> regOut[WIDTH-1:0] == $past(regOut[N*WIDTH-1 -: WIDTH])); // R3

  AST_MINUSR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !regLoad && maskLoad && (&maskIn) && funcSel == 2'b11)
    |=> regOut[WIDTH-1:0] == $past(regOut[SIDE*WIDTH +: WIDTH])); // R6

  AST_MASKED_NO_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !regLoad && maskLoad && maskIn == '0) |=> $stable(regOut)); // R7

  AST_DONE_FOLLOWS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !regLoad) |=> ##1 done); // R9

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(stepStrobe, 2) && !$past(regLoad, 2))); // R9

endmodule

bind mesh_route_top mesh_route_chk #(.SIDE(SIDE), .WIDTH(WIDTH)) uChk (.*);

// File: tb/tb_mesh_route_top.sv
module tb_mesh_route_top;
  localparam int SIDE  = 8;
  localparam int WIDTH = 8;
  localparam int N     = SIDE * SIDE;
  localparam int NV    = 12;

  // {funcSel, mask}
  localparam logic [N+1:0] VEC [NV] = '{
    {2'b00, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b01, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b10, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b11, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b00, 64'h5555_5555_5555_5555},
    {2'b01, 64'hAAAA_AAAA_AAAA_AAAA},
    {2'b10, 64'h00FF_00FF_00FF_00FF},
    {2'b11, 64'hF0F0_0F0F_3C3C_C3C3},
    {2'b00, 64'h0000_0000_0000_0000},
    {2'b10, 64'h8000_0000_0000_0001},
    {2'b01, 64'h1234_5678_9ABC_DEF0},
    {2'b11, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic               regLoad = 1'b0;
  logic [N*WIDTH-1:0] regIn = '0;
  logic               maskLoad = 1'b0;
  logic [N-1:0]       maskIn = '0;
  logic               stepStrobe = 1'b0;
  logic [1:0]         funcSel = 2'b00;
  logic [N*WIDTH-1:0] regOut;
  logic               done;

  logic [WIDTH-1:0] mdl [N];
  logic [N-1:0]     mdlMask;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mesh_route_top #(.SIDE(SIDE), .WIDTH(WIDTH)) dut (.*);

  task automatic chkVec(input string req, input logic [N*WIDTH-1:0] act, input logic [N*WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: regOut actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: done actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [N*WIDTH-1:0] packMdl();
    logic [N*WIDTH-1:0] v;
    for (int j = 0; j < N; j++) v[j*WIDTH +: WIDTH] = mdl[j];
    return v;
  endfunction

  task automatic mdlStep(input logic [1:0] f, input logic [N-1:0] m);
    logic [WIDTH-1:0] old [N];
    for (int j = 0; j < N; j++) old[j] = mdl[j];
    for (int i = 0; i < N; i++) begin
      int d;
      case (f)
        2'b00:   d = (i + 1) % N;
        2'b01:   d = (i + N - 1) % N;
        2'b10:   d = (i + SIDE) % N;
        default: d = (i + N - SIDE) % N;
      endcase
      if (m[i]) mdl[d] = old[i];
    end
  endtask

  task automatic loadRegs(input int seed);
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      regIn[j*WIDTH +: WIDTH] = WIDTH'(j * 3 + seed);
      mdl[j] = WIDTH'(j * 3 + seed);
    end
    regLoad = 1'b1;
    @(negedge clk);
    regLoad = 1'b0;
    chkVec("R2", regOut, packMdl());
  endtask

  task automatic doStep(input logic [1:0] f, input logic [N-1:0] m, input bit useMask, input string req);
    @(negedge clk);
    funcSel = f; stepStrobe = 1'b1; maskLoad = useMask; maskIn = m;
    if (useMask) mdlMask = m;
    mdlStep(f, mdlMask);
    @(negedge clk);
    stepStrobe = 1'b0; maskLoad = 1'b0;
    chkVec(req, regOut, packMdl());
    chkBit("R9", done, 1'b0);
    @(negedge clk);
    chkBit("R9", done, 1'b1);
    @(negedge clk);
    chkBit("R9", done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    string names [4] = '{"R3", "R4", "R5", "R6"};
    rstN = 1'b0;
    mdlMask = '1;
    repeat (3) @(negedge clk);
    chkVec("R1", regOut, '0);
    chkBit("R1", done, 1'b0);
    rstN = 1'b1;

    loadRegs(1);
    // R1: flags come out of reset all enabled, so a step with no mask load rotates everything
    doStep(2'b00, '0, 1'b0, "R1");

    // R10: idle cycles hold
    repeat (3) @(negedge clk);
    chkVec("R10", regOut, packMdl());

    for (int v = 0; v < NV; v++) begin
      logic [1:0]   f = VEC[v][N+1:N];
      logic [N-1:0] m = VEC[v][N-1:0];
      doStep(f, m, 1'b1, (m != '1) ? "R7" : names[f]);
    end

    // R2: load wins over a simultaneous step, no done follows
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      regIn[j*WIDTH +: WIDTH] = WIDTH'(200 - j);
      mdl[j] = WIDTH'(200 - j);
    end
    regLoad = 1'b1; stepStrobe = 1'b1; funcSel = 2'b10;
    @(negedge clk);
    regLoad = 1'b0; stepStrobe = 1'b0;
    chkVec("R2", regOut, packMdl());
    @(negedge clk);
    chkBit("R2", done, 1'b0);
    @(negedge clk);
    chkBit("R2", done, 1'b0);

    // R8: mask loaded alone persists for later steps
    @(negedge clk);
    maskIn = 64'h0F0F_F0F0_00FF_FF00; maskLoad = 1'b1;
    mdlMask = 64'h0F0F_F0F0_00FF_FF00;
    @(negedge clk);
    maskLoad = 1'b0; maskIn = '1;
    chkVec("R10", regOut, packMdl());
    doStep(2'b01, '0, 1'b0, "R8");
    doStep(2'b10, '0, 1'b0, "R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule